// File: doc/BRIEF.md
# Reference Loss Auto Power-Down Monitor

This block decides whether the selected reference clock is healthy enough to keep a clock-distribution PLL and its outputs running. A free-running timebase clock cuts time into fixed windows. Every rising edge of the reference is carried into the timebase domain as a single-cycle pulse. At the end of each window the block compares the pulse total against a programmed minimum. Too few edges means the reference has slowed below its lower frequency bound, or has stopped.

A power-down request is raised only after two windows in a row fall short. It is withdrawn only after two windows in a row meet the minimum. This hysteresis stops the request from chattering when the reference sits near the limit. The request is meant to stop the PLL and gate the output pairs.

The monitor has an enable bit. It also switches itself off whenever any output pair is fed straight from the reference, because a stopped reference is then a legitimate state of the outputs. A pair is fed from the reference in two cases:
- its source code selects the reference;
- the divider-source bit routes the reference into the dividers and the pair uses one of those dividers.

Top module: `refmon_autopdn`

## Requirements
- R1: While reset is asserted, and right after it is released, `pdn_req` is 0 and `ref_good` is 1.
- R2: Each rising edge of `ref_clk` adds exactly one to the count of the current window. A window lasts WIN_CYCLES (default 64) cycles of `tb_clk`. A reference that delivers at least `low_limit` edges in every window keeps `pdn_req` at 0 and `ref_good` at 1.
- R3: After any window that closes with fewer than `low_limit` edges, `ref_good` is 0 from the next timebase cycle on. After any window that closes with at least `low_limit` edges, `ref_good` is 1.
- R4: `pdn_req` rises only on the close of the second of two consecutive short windows. A single short window between adequate ones leaves it at 0.
- R5: Once raised, `pdn_req` falls only on the close of the second of two consecutive adequate windows, or when the monitor becomes inactive. A single adequate window between short ones leaves it at 1.
- R6: A reference that stops entirely produces zero-count windows and therefore drives `pdn_req` to 1.
- R7: With `mon_en` at 0, `pdn_req` is 0 and `ref_good` is 1 from the next cycle on. Setting `mon_en` back to 1 starts a fresh window from a zero count.
- R8: `pair_src` holds one 3-bit code per output pair, with pair i at bits [3i+2:3i]. If any pair carries code 0 (reference passed straight through), the monitor is inactive with the same outputs as in R7.
- R9: With `div_src_ref` at 1, any pair code from 1 to 6 also makes the monitor inactive. Code 7 (lock test output) never does, whatever the setting of `div_src_ref`.
- R10: While the monitor is active, `pdn_req` and `ref_good` change only in the cycle that follows a window close.
- R11: A window count equal to `low_limit` counts as adequate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tb_clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| ref_clk | input | 1 | Selected reference clock being watched |
| mon_en | input | 1 | Monitor enable (1 = enabled) |
| div_src_ref | input | 1 | 1 = output dividers are fed from the reference rather than the PLL |
| pair_src | input | NUM_PAIRS*3 | Per-pair output source codes, pair i at bits [3i+2:3i] |
| low_limit | input | CNT_W | Minimum edges per window for a healthy reference |
| pdn_req | output | 1 | Power-down request for the PLL and output gating |
| ref_good | output | 1 | Most recent window met the minimum (held at 1 while inactive) |

## Verification
The hardest situation to reach from the ports is a window whose count lands exactly on the threshold. Window phase is invisible outside the block, so an arbitrary reference gives counts that wander by one from window to window. The bench therefore runs the reference at a period that divides the window length. That makes every steady window hold an exact, known count. The bench then moves `low_limit` one step above or onto that count, for exactly one window or for two, to reach the equality boundary and the single-dip hysteresis cases. Window closes are tracked by the bench's own model, so checks land on the cycle just after a chosen close.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  // Width of one output pair's source code.
  localparam int SRC_W = 3;

  // Source code values with behavioural meaning for the monitor.
  localparam logic [SRC_W-1:0] SRC_REF_DIRECT = 3'd0;
  localparam logic [SRC_W-1:0] SRC_LOCK_TEST  = 3'd7;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_DOWN = 1'b1
  } pd_state_t;

  // A pair is clocked straight from the reference when it passes the
  // reference through, or when it uses a divider while the dividers are
  // themselves fed from the reference.
  function automatic logic src_uses_ref(input logic [SRC_W-1:0] code,
                                        input logic div_from_ref);
    logic through;
    logic divided;
    through = (code == SRC_REF_DIRECT);
    divided = div_from_ref && (code != SRC_REF_DIRECT) && (code != SRC_LOCK_TEST);
    return through || divided;
  endfunction

  // Count reached at the close of a window, including the pulse of the
  // closing cycle.
  function automatic int unsigned window_total(input int unsigned held,
                                               input logic pulse);
    return held + (pulse ? 1 : 0);
  endfunction

  // A window is short when its count is strictly under the limit.
  function automatic logic window_short(input int unsigned total,
                                        input int unsigned limit);
    return total < limit;
  endfunction

endpackage

// File: rtl/refmon_toggle_sync.sv
module refmon_toggle_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic tb_clk,
  input  logic rst_n,
  output logic edge_pulse
);

  // Reference domain: one toggle per rising edge, so only a single bit
  // ever crosses into the timebase domain.
  logic ref_tog;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_tog <= 1'b0;
    else        ref_tog <= ~ref_tog;
  end

  // Timebase domain: synchronizer stages plus one history stage.
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge tb_clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], ref_tog};
  end

  // Each change of the synchronized toggle is one reference edge.
  assign edge_pulse = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/refmon_bypass_detect.sv
module refmon_bypass_detect
  import refmon_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  localparam int SEL_W = NUM_PAIRS * SRC_W
) (
  input  logic [SEL_W-1:0] pair_src,
  input  logic             div_src_ref,
  output logic             ref_bypass
);

  logic [NUM_PAIRS-1:0] pair_hit;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_hit[p] = src_uses_ref(pair_src[p*SRC_W +: SRC_W], div_src_ref);
  end

  assign ref_bypass = |pair_hit;

endmodule

// File: rtl/refmon_window.sv
module refmon_window
  import refmon_pkg::*;
#(
  parameter int WIN_CYCLES = 64,
  localparam int CNT_W = $clog2(WIN_CYCLES + 1),
  localparam int PH_W  = $clog2(WIN_CYCLES)
) (
  input  logic             tb_clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             edge_pulse,
  output logic             win_close,
  output logic [CNT_W-1:0] win_total
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(WIN_CYCLES - 1);

  logic [PH_W-1:0]  phase_q;
  logic [CNT_W-1:0] edges_q;

  assign win_close = active && (phase_q == LAST_PH);
  assign win_total = CNT_W'(window_total(int'(edges_q), edge_pulse));

  always_ff @(posedge tb_clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      edges_q <= '0;
    end else if (!active || win_close) begin
      phase_q <= '0;
      edges_q <= '0;
    end else begin
      phase_q <= phase_q + PH_W'(1);
      edges_q <= win_total;
    end
  end

endmodule

// File: rtl/refmon_hysteresis.sv
module refmon_hysteresis
  import refmon_pkg::*;
#(
  parameter int CONFIRM = 2,
  localparam int STK_W = $clog2(CONFIRM + 1)
) (
  input  logic tb_clk,
  input  logic rst_n,
  input  logic active,
  input  logic win_close,
  input  logic win_low,
  output logic pdn_req,
  output logic ref_good
);

  localparam logic [STK_W-1:0] STK_LAST = STK_W'(CONFIRM - 1);

  pd_state_t        state_q;
  logic [STK_W-1:0] streak_q;
  logic             good_q;
  logic             against_state;

  // A window pushes towards a state change when it disagrees with the
  // current state: short while running, adequate while powered down.
  assign against_state = (state_q == ST_RUN) ? win_low : !win_low;

  always_ff @(posedge tb_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      streak_q <= '0;
      good_q   <= 1'b1;
    end else if (!active) begin
      state_q  <= ST_RUN;
      streak_q <= '0;
      good_q   <= 1'b1;
    end else if (win_close) begin
      good_q <= !win_low;
      if (!against_state) begin
        streak_q <= '0;
      end else if (streak_q == STK_LAST) begin
        streak_q <= '0;
        state_q  <= (state_q == ST_RUN) ? ST_DOWN : ST_RUN;
      end else begin
        streak_q <= streak_q + STK_W'(1);
      end
    end
  end

  assign pdn_req  = (state_q == ST_DOWN);
  assign ref_good = good_q;

endmodule

// File: rtl/refmon_autopdn.sv
module refmon_autopdn
  import refmon_pkg::*;
#(
  parameter int NUM_PAIRS   = 6,
  parameter int WIN_CYCLES  = 64,
  parameter int CONFIRM     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(WIN_CYCLES + 1),
  localparam int SEL_W = NUM_PAIRS * SRC_W
) (
  input  logic             tb_clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             mon_en,
  input  logic             div_src_ref,
  input  logic [SEL_W-1:0] pair_src,
  input  logic [CNT_W-1:0] low_limit,
  output logic             pdn_req,
  output logic             ref_good
);

  // Named internal events, also observed by the bound checker.
  logic             edge_pulse;
  logic             ref_bypass;
  logic             mon_active;
  logic             win_close;
  logic [CNT_W-1:0] win_total;
  logic             win_low;

  refmon_toggle_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .ref_clk   (ref_clk),
    .tb_clk    (tb_clk),
    .rst_n     (rst_n),
    .edge_pulse(edge_pulse)
  );

  refmon_bypass_detect #(
    .NUM_PAIRS(NUM_PAIRS)
  ) u_bypass (
    .pair_src   (pair_src),
    .div_src_ref(div_src_ref),
    .ref_bypass (ref_bypass)
  );

  assign mon_active = mon_en && !ref_bypass;

  refmon_window #(
    .WIN_CYCLES(WIN_CYCLES)
  ) u_window (
    .tb_clk    (tb_clk),
    .rst_n     (rst_n),
    .active    (mon_active),
    .edge_pulse(edge_pulse),
    .win_close (win_close),
    .win_total (win_total)
  );

  assign win_low = window_short(int'(win_total), int'(low_limit));

  refmon_hysteresis #(
    .CONFIRM(CONFIRM)
  ) u_hyst (
    .tb_clk   (tb_clk),
    .rst_n    (rst_n),
    .active   (mon_active),
    .win_close(win_close),
    .win_low  (win_low),
    .pdn_req  (pdn_req),
    .ref_good (ref_good)
  );

endmodule

// File: rtl/refmon_autopdn_chk.sv
module refmon_autopdn_chk (
  input logic tb_clk,
  input logic rst_n,
  input logic mon_en,
  input logic ref_bypass,
  input logic mon_active,
  input logic win_close,
  input logic win_low,
  input logic pdn_req,
  input logic ref_good
);

  assert_disable_quiet_R7: assert property (@(posedge tb_clk) disable iff (!rst_n)
    !mon_en |=> (!pdn_req && ref_good));

  assert_bypass_quiet_R8: assert property (@(posedge tb_clk) disable iff (!rst_n)
    ref_bypass |=> (!pdn_req && ref_good));

  assert_hold_between_closes_R10: assert property (@(posedge tb_clk) disable iff (!rst_n)
    (mon_active && !win_close) |=> ($stable(pdn_req) && $stable(ref_good)));

  assert_short_clears_flag_R3: assert property (@(posedge tb_clk) disable iff (!rst_n)
    (mon_active && win_close && win_low) |=> !ref_good);

  assert_rise_after_short_R4: assert property (@(posedge tb_clk) disable iff (!rst_n)
    $rose(pdn_req) |-> $past(win_close && win_low));

  assert_fall_after_good_R5: assert property (@(posedge tb_clk) disable iff (!rst_n)
    $fell(pdn_req) |-> $past(!mon_active || (win_close && !win_low)));

endmodule

bind refmon_autopdn refmon_autopdn_chk u_chk (
  .tb_clk    (tb_clk),
  .rst_n     (rst_n),
  .mon_en    (mon_en),
  .ref_bypass(ref_bypass),
  .mon_active(mon_active),
  .win_close (win_close),
  .win_low   (win_low),
  .pdn_req   (pdn_req),
  .ref_good  (ref_good)
);

// File: tb/refmon_autopdn_bench.sv
module refmon_autopdn_bench;

  localparam int NP  = 6;
  localparam int WIN = 64;
  localparam int CW  = $clog2(WIN + 1);

  logic              tb_clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_clk = 1'b0;
  logic              mon_en = 1'b1;
  logic              div_src_ref = 1'b0;
  logic [NP*3-1:0]   pair_src = {NP{3'd2}};
  logic [CW-1:0]     low_limit = CW'(6);
  logic              pdn_req;
  logic              ref_good;

  always #5 tb_clk = ~tb_clk;

  refmon_autopdn u_refmon_autopdn (
    .tb_clk     (tb_clk),
    .rst_n      (rst_n),
    .ref_clk    (ref_clk),
    .mon_en     (mon_en),
    .div_src_ref(div_src_ref),
    .pair_src   (pair_src),
    .low_limit  (low_limit),
    .pdn_req    (pdn_req),
    .ref_good   (ref_good)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    checking = 1'b0;
  bit    done = 1'b0;

  // Reference generator: half period in timebase cycles, 0 = stopped.
  int ref_half = 0;
  int ref_rises = 0;

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge tb_clk);
      if (ref_half == 0) begin
        ref_clk = 1'b0;
        ph = 0;
      end else begin
        ph++;
        if (ph >= ref_half) begin
          ph = 0;
          ref_clk = ~ref_clk;
          if (ref_clk) ref_rises++;
        end
      end
    end
  end

  // Does any pair take the reference directly?
  function automatic bit takes_ref(input logic [NP*3-1:0] s, input logic d);
    for (int i = 0; i < NP; i++) begin
      int c;
      c = int'(s >> (3 * i)) % 8;
      if (c == 0) return 1'b1;
      if (d && c >= 1 && c <= 6) return 1'b1;
    end
    return 1'b0;
  endfunction

  // Behavioural reference model, advanced on every timebase edge.
  int pend_q[$];
  int seen_rises = 0;
  int m_phase = 0;
  int m_count = 0;
  int m_short_run = 0;
  int m_good_run = 0;
  bit m_down = 1'b0;
  bit m_good = 1'b1;
  int n_close = 0;

  always @(posedge tb_clk) begin
    int pulse;
    int total;
    bit act;
    bit short_win;
    if (!rst_n) begin
      pend_q = '{0, 0};
      seen_rises = ref_rises;
      m_phase = 0; m_count = 0; m_short_run = 0; m_good_run = 0;
      m_down = 1'b0; m_good = 1'b1;
    end else begin
      // Two timebase edges of crossing latency before a rise is counted.
      pulse = pend_q.pop_front();
      pend_q.push_back((ref_rises != seen_rises) ? 1 : 0);
      seen_rises = ref_rises;
      act = mon_en && !takes_ref(pair_src, div_src_ref);
      if (!act) begin
        m_phase = 0; m_count = 0; m_short_run = 0; m_good_run = 0;
        m_down = 1'b0; m_good = 1'b1;
      end else if (m_phase == WIN - 1) begin
        total = m_count + pulse;
        short_win = (total < int'(low_limit));
        m_good = !short_win;
        if (!m_down) begin
          m_short_run = short_win ? m_short_run + 1 : 0;
          if (m_short_run == 2) begin m_down = 1'b1; m_short_run = 0; end
        end else begin
          m_good_run = short_win ? 0 : m_good_run + 1;
          if (m_good_run == 2) begin m_down = 1'b0; m_good_run = 0; end
        end
        m_phase = 0; m_count = 0;
        n_close++;
      end else begin
        m_phase++;
        m_count += pulse;
      end
    end
  end

  // Cycle-by-cycle comparison against the model (R10 stability included).
  always @(negedge tb_clk) begin
    if (rst_n && checking && !done) begin
      vectors++;
      if (pdn_req !== m_down || ref_good !== m_good) begin
        miscompares++;
        $display("FAIL %s (model, R10): pdn_req=%b ref_good=%b expected %b %b at %0t",
                 cur_req, pdn_req, ref_good, m_down, m_good, $time);
      end
    end
  end

  task automatic check(input string tag, input bit exp_pdn, input bit exp_good);
    vectors++;
    if (pdn_req !== exp_pdn || ref_good !== exp_good) begin
      miscompares++;
      $display("FAIL %s: pdn_req=%b ref_good=%b expected %b %b at %0t",
               tag, pdn_req, ref_good, exp_pdn, exp_good, $time);
    end
  endtask

  task automatic wait_closes(input int k);
    int target;
    target = n_close + k;
    while (n_close < target) @(negedge tb_clk);
  endtask

  task automatic set_pair(input int idx, input logic [2:0] code);
    @(negedge tb_clk);
    pair_src[idx*3 +: 3] = code;
  endtask

  // Watchdog: an expired run counts as one failed check.
  initial begin
    repeat (150000) @(posedge tb_clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    ref_half = 2;
    repeat (4) @(negedge tb_clk);
    check("R1 in reset", 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge tb_clk);
    check("R1 after release", 1'b0, 1'b1);
    checking = 1'b1;

    // R2: fast reference, 16 edges per window against a limit of 6.
    cur_req = "R2";
    wait_closes(3);
    check("R2 healthy reference", 1'b0, 1'b1);

    // R11: period 8 gives exactly 8 edges per window.
    cur_req = "R11";
    @(negedge tb_clk); ref_half = 4;
    wait_closes(2);
    @(negedge tb_clk); low_limit = CW'(8);
    wait_closes(2);
    check("R11 count equals limit", 1'b0, 1'b1);

    // R3 and R4: limit one above the count.
    cur_req = "R3";
    @(negedge tb_clk); low_limit = CW'(9);
    wait_closes(1);
    check("R3 first short window", 1'b0, 1'b0);
    cur_req = "R4";
    wait_closes(1);
    check("R4 second short window", 1'b1, 1'b0);

    // R5: release needs two adequate windows.
    cur_req = "R5";
    @(negedge tb_clk); low_limit = CW'(8);
    wait_closes(1);
    check("R5 one good window holds", 1'b1, 1'b1);
    wait_closes(1);
    check("R5 two good windows release", 1'b0, 1'b1);

    // R4: a lone short window does not assert.
    cur_req = "R4";
    @(negedge tb_clk); low_limit = CW'(9);
    wait_closes(1);
    check("R4 lone dip", 1'b0, 1'b0);
    @(negedge tb_clk); low_limit = CW'(8);
    wait_closes(2);
    check("R4 after lone dip", 1'b0, 1'b1);

    // R5: a lone good window inside a power-down does not release.
    cur_req = "R5";
    @(negedge tb_clk); low_limit = CW'(9);
    wait_closes(2);
    check("R5 down again", 1'b1, 1'b0);
    @(negedge tb_clk); low_limit = CW'(8);
    wait_closes(1);
    @(negedge tb_clk); low_limit = CW'(9);
    wait_closes(1);
    check("R5 lone good window", 1'b1, 1'b0);
    @(negedge tb_clk); low_limit = CW'(8);
    wait_closes(2);
    check("R5 released", 1'b0, 1'b1);

    // R6: stopped reference.
    cur_req = "R6";
    @(negedge tb_clk); ref_half = 0;
    wait_closes(3);
    check("R6 stopped reference", 1'b1, 1'b0);
    @(negedge tb_clk); ref_half = 4;
    wait_closes(3);
    check("R6 edges return", 1'b0, 1'b1);

    // R7: enable bit.
    cur_req = "R7";
    @(negedge tb_clk); ref_half = 0;
    wait_closes(3);
    check("R7 down before disable", 1'b1, 1'b0);
    @(negedge tb_clk); mon_en = 1'b0;
    repeat (2) @(negedge tb_clk);
    check("R7 disabled", 1'b0, 1'b1);
    repeat (200) @(negedge tb_clk);
    check("R7 stays disabled", 1'b0, 1'b1);
    @(negedge tb_clk); mon_en = 1'b1;
    wait_closes(1);
    check("R7 fresh window, one short", 1'b0, 1'b0);
    wait_closes(1);
    check("R7 re-enabled", 1'b1, 1'b0);

    // R8: a pair passing the reference straight through.
    cur_req = "R8";
    set_pair(3, 3'd0);
    repeat (2) @(negedge tb_clk);
    check("R8 pair 3 direct", 1'b0, 1'b1);
    repeat (150) @(negedge tb_clk);
    check("R8 stays inactive", 1'b0, 1'b1);
    set_pair(3, 3'd2);
    wait_closes(2);
    check("R8 active again", 1'b1, 1'b0);

    // R9: dividers fed from the reference.
    cur_req = "R9";
    @(negedge tb_clk); div_src_ref = 1'b1;
    repeat (2) @(negedge tb_clk);
    check("R9 dividers on reference", 1'b0, 1'b1);
    @(negedge tb_clk); pair_src = {NP{3'd7}};
    wait_closes(2);
    check("R9 lock test code ignored", 1'b1, 1'b0);
    set_pair(5, 3'd4);
    repeat (2) @(negedge tb_clk);
    check("R9 pair 5 divide", 1'b0, 1'b1);
    @(negedge tb_clk); div_src_ref = 1'b0;
    wait_closes(2);
    check("R9 dividers back on PLL", 1'b1, 1'b0);

    repeat (4) @(negedge tb_clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule